// File: doc/BRIEF.md
# Clock-Alarm Interrupt Emulation Engine

This block rebuilds the three interrupt sources of a legacy real-time clock from a single polled tick. The sources are the seconds-update event, the time-of-day alarm and the periodic interrupt. A free-running time count `now_i` is compared against an internal deadline. Each time the deadline is reached, the engine services one tick. During that tick it compares the current hours, minutes and seconds against the stored alarm and against the last seconds value it saw. It also steps the periodic divider.

The periodic rate is selected as a power of two from 2 Hz to 8192 Hz. At 64 Hz and below, the tick keeps its default interval (`BASE_IV` counts of `now_i`, standing for 1/64 s) and a divider counts ticks. Above 64 Hz the tick interval itself is shortened. When ticks are serviced late, the deadline is stepped forward in whole intervals, and the skipped intervals are credited to the periodic divider. When a tick raises a flag, the flags are latched into a word with a summary bit and an interrupt count. A one-cycle interrupt pulse marks the event, and the word is held until the host acknowledges it.

Top module: `rtcemu_core`

## Requirements
- R1: After reset `flags_o` is 0, `irq_o` is 0 and `timer_on_o` is 0.
- R2: When any enable rises while all three were clear, the deadline is armed to `now_i` + interval in the next clock, `timer_on_o` rises, and no tick is serviced while `now_i` is below that deadline.
- R3: For rate codes 1 to 6 (2^code Hz), the periodic flag is raised on every 2^(6-code)-th serviced tick, and the divider count then returns to zero.
- R4: For rate codes 7 to 13 with the periodic source enabled, the tick interval is `BASE_IV` >> (code-6), and every serviced tick raises the periodic flag.
- R5: A rate code of 0 is treated as 1, and a rate code above 13 is treated as 13.
- R6: With update enabled, a serviced tick raises the update flag (bit 4) when `ss_i` differs from the stored seconds value, and the stored value then becomes `ss_i`. The stored value is 0 after reset.
- R7: With alarm enabled, a serviced tick raises the alarm flag (bit 5) when hours, minutes and seconds all equal the alarm inputs.
- R8: If the deadline has already passed, it is advanced by whole intervals until it is no longer behind `now_i`. Each extra interval adds one to the periodic divider count. The periodic flag is bit 6.
- R9: `irq_o` pulses only on a serviced tick that raised at least one flag. Whenever flags are latched, bit 7 is set, bits 15:8 hold 1, and bits 3:0 stay 0.
- R10: When all three enables are clear, `timer_on_o` falls on the next clock and no tick is serviced.
- R11: Latched flags are held until `ack_i`. A new event ORs its flags into the held word, and `ack_i` clears the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_i | input | 16 | Free-running time count |
| en_upd_i | input | 1 | Update source enable |
| en_alm_i | input | 1 | Alarm source enable |
| en_per_i | input | 1 | Periodic source enable |
| rate_i | input | 4 | Periodic rate code, rate = 2^code Hz |
| hh_i | input | 6 | Current hours |
| mm_i | input | 6 | Current minutes |
| ss_i | input | 6 | Current seconds |
| alm_hh_i | input | 6 | Alarm hours |
| alm_mm_i | input | 6 | Alarm minutes |
| alm_ss_i | input | 6 | Alarm seconds |
| ack_i | input | 1 | Host acknowledge, clears held flags |
| irq_o | output | 1 | One-cycle interrupt pulse |
| flags_o | output | 16 | Held flag word |
| timer_on_o | output | 1 | Tick channel running |

## Verification
The bench steps `now_i` one count below and exactly onto a freshly armed deadline. An engine that arms off by one interval, or services a tick early, produces a pulse in the wrong window. A late-serviced tick three intervals behind is used to check the catch-up. An engine that drops the skipped intervals keeps the periodic flag clear when it should be set. A divider that fails to clear would instead raise the flag one tick early on the next pass. Two further cases are an out-of-range rate code and a second event arriving before acknowledge. A missing clamp fires at once, and a missing OR loses the earlier periodic bit.

// File: rtl/rtcemu_pkg.sv
`timescale 1ns/1ps
package rtcemu_pkg;
  localparam int FLAG_W   = 16;
  localparam int UPD_BIT  = 4;
  localparam int ALM_BIT  = 5;
  localparam int PER_BIT  = 6;
  localparam int SUM_BIT  = 7;
  localparam int CNT_LSB  = 8;
  localparam int RATE_W   = 4;
  localparam int RATE_MIN = 1;
  localparam int RATE_MAX = 13;
  localparam int RATE_REF = 6;   // code of the default poll rate
  localparam int LIM_W    = 6;

  typedef enum logic [1:0] {
    DL_IDLE  = 2'd0,
    DL_WAIT  = 2'd1,
    DL_CATCH = 2'd2
  } dl_state_e;
endpackage

// File: rtl/rtcemu_rate.sv
`timescale 1ns/1ps
module rtcemu_rate
  import rtcemu_pkg::*;
#(
  parameter int CW      = 16,
  parameter int BASE_IV = 128
) (
  input  logic [RATE_W-1:0] rate_i,
  input  logic              per_en_i,
  output logic [CW-1:0]     iv_o,
  output logic [LIM_W-1:0]  limit_o
);
  localparam logic [CW-1:0] BASE = CW'(BASE_IV);

  logic [RATE_W-1:0] code;

  always_comb begin
    code = rate_i;
    if (rate_i < RATE_W'(RATE_MIN)) code = RATE_W'(RATE_MIN);
    if (rate_i > RATE_W'(RATE_MAX)) code = RATE_W'(RATE_MAX);
  end

  always_comb begin
    iv_o    = BASE;
    limit_o = '0;
    if (code <= RATE_W'(RATE_REF)) begin
      limit_o = LIM_W'(1) << (RATE_W'(RATE_REF) - code);
    end else if (per_en_i) begin
      iv_o = BASE >> (code - RATE_W'(RATE_REF));
    end
  end
endmodule

// File: rtl/rtcemu_deadline.sv
`timescale 1ns/1ps
module rtcemu_deadline
  import rtcemu_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] now_i,
  input  logic [CW-1:0] iv_i,
  input  logic          any_en_i,
  output logic          svc_o,
  output logic [CW-1:0] lost_o,
  output logic          timer_on_o
);
  dl_state_e          st_q, st_d;
  logic [CW-1:0]        dl_q, dl_d;
  logic [CW-1:0]        lost_q, lost_d;
  logic                 dl_en, lost_en;
  logic signed [CW-1:0] gap;

  assign gap = now_i - dl_q;

  always_comb begin
    st_d    = st_q;
    dl_d    = dl_q;
    lost_d  = lost_q;
    dl_en   = 1'b0;
    lost_en = 1'b0;
    svc_o   = 1'b0;
    case (st_q)
      DL_IDLE: begin
        if (any_en_i) begin
          dl_d  = now_i + iv_i;
          dl_en = 1'b1;
          st_d  = DL_WAIT;
        end
      end
      DL_WAIT: begin
        if (!any_en_i) begin
          st_d = DL_IDLE;
        end else if (gap >= 0) begin
          dl_d    = dl_q + iv_i;
          dl_en   = 1'b1;
          lost_d  = '0;
          lost_en = 1'b1;
          st_d    = DL_CATCH;
        end
      end
      DL_CATCH: begin
        if (!any_en_i) begin
          st_d = DL_IDLE;
        end else if (gap > 0) begin
          dl_d    = dl_q + iv_i;
          dl_en   = 1'b1;
          lost_d  = lost_q + 1'b1;
          lost_en = 1'b1;
        end else begin
          svc_o = 1'b1;
          st_d  = DL_WAIT;
        end
      end
      default: st_d = DL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DL_IDLE;
      dl_q   <= '0;
      lost_q <= '0;
    end else begin
      st_q <= st_d;
      if (dl_en)   dl_q   <= dl_d;
      if (lost_en) lost_q <= lost_d;
    end
  end

  assign lost_o     = lost_q;
  assign timer_on_o = (st_q != DL_IDLE);
endmodule

// File: rtl/rtcemu_pdiv.sv
`timescale 1ns/1ps
module rtcemu_pdiv
  import rtcemu_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_i,
  input  logic             per_en_i,
  input  logic [CW-1:0]    lost_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             hit_o
);
  localparam int DW = CW + 1;

  logic [DW-1:0] cnt_q, cnt_d, sum;
  logic          cnt_en;

  always_comb begin
    sum    = cnt_q + DW'(lost_i) + DW'(1);
    hit_o  = svc_i && per_en_i && (sum >= DW'(limit_i));
    cnt_en = svc_i && per_en_i;
    cnt_d  = hit_o ? '0 : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtcemu_flags.sv
`timescale 1ns/1ps
module rtcemu_flags
  import rtcemu_pkg::*;
#(
  parameter int TW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              svc_i,
  input  logic              per_hit_i,
  input  logic              en_upd_i,
  input  logic              en_alm_i,
  input  logic [TW-1:0]     hh_i,
  input  logic [TW-1:0]     mm_i,
  input  logic [TW-1:0]     ss_i,
  input  logic [TW-1:0]     alm_hh_i,
  input  logic [TW-1:0]     alm_mm_i,
  input  logic [TW-1:0]     alm_ss_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] flags_q, flags_d, src;
  logic [TW-1:0]     prev_q, prev_d;
  logic              irq_q, irq_d;
  logic              new_upd, new_alm, ev;

  always_comb begin
    new_upd = svc_i && en_upd_i && (ss_i != prev_q);
    new_alm = svc_i && en_alm_i && (hh_i == alm_hh_i) &&
              (mm_i == alm_mm_i) && (ss_i == alm_ss_i);
    ev      = new_upd || new_alm || per_hit_i;
    src     = '0;
    src[UPD_BIT] = new_upd;
    src[ALM_BIT] = new_alm;
    src[PER_BIT] = per_hit_i;
    flags_d = ack_i ? '0 : flags_q;
    if (ev) begin
      flags_d = flags_d | src;
      flags_d[SUM_BIT] = 1'b1;
      flags_d[FLAG_W-1:CNT_LSB] = (FLAG_W-CNT_LSB)'(1);
    end
    irq_d  = ev;
    prev_d = new_upd ? ss_i : prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      prev_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      prev_q  <= prev_d;
      irq_q   <= irq_d;
    end
  end

  assign irq_o   = irq_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/rtcemu_core.sv
`timescale 1ns/1ps
module rtcemu_core
  import rtcemu_pkg::*;
#(
  parameter int CW      = 16,
  parameter int BASE_IV = 128,
  parameter int TW      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     now_i,
  input  logic              en_upd_i,
  input  logic              en_alm_i,
  input  logic              en_per_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [TW-1:0]     hh_i,
  input  logic [TW-1:0]     mm_i,
  input  logic [TW-1:0]     ss_i,
  input  logic [TW-1:0]     alm_hh_i,
  input  logic [TW-1:0]     alm_mm_i,
  input  logic [TW-1:0]     alm_ss_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              timer_on_o
);
  logic             rst_s0, rst_sync_n;
  logic [CW-1:0]    iv, lost;
  logic [LIM_W-1:0] limit;
  logic             svc, per_hit, any_en;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_sync_n <= rst_s0;
    end
  end

  assign any_en = en_upd_i || en_alm_i || en_per_i;

  rtcemu_rate #(.CW(CW), .BASE_IV(BASE_IV)) i_rate (
    .rate_i  (rate_i),
    .per_en_i(en_per_i),
    .iv_o    (iv),
    .limit_o (limit)
  );

  rtcemu_deadline #(.CW(CW)) i_deadline (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .now_i     (now_i),
    .iv_i      (iv),
    .any_en_i  (any_en),
    .svc_o     (svc),
    .lost_o    (lost),
    .timer_on_o(timer_on_o)
  );

  rtcemu_pdiv #(.CW(CW)) i_pdiv (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .svc_i   (svc),
    .per_en_i(en_per_i),
    .lost_i  (lost),
    .limit_i (limit),
    .hit_o   (per_hit)
  );

  rtcemu_flags #(.TW(TW)) i_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .svc_i    (svc),
    .per_hit_i(per_hit),
    .en_upd_i (en_upd_i),
    .en_alm_i (en_alm_i),
    .hh_i     (hh_i),
    .mm_i     (mm_i),
    .ss_i     (ss_i),
    .alm_hh_i (alm_hh_i),
    .alm_mm_i (alm_mm_i),
    .alm_ss_i (alm_ss_i),
    .ack_i    (ack_i),
    .irq_o    (irq_o),
    .flags_o  (flags_o)
  );
endmodule

// File: rtl/rtcemu_chk.sv
`timescale 1ns/1ps
module rtcemu_chk
  import rtcemu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en_upd_i,
  input logic              en_alm_i,
  input logic              en_per_i,
  input logic              ack_i,
  input logic              irq_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic              timer_on_o
);
  assert_irq_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flags_o[SUM_BIT] && flags_o[FLAG_W-1:CNT_LSB] == 8'd1 &&
               flags_o[PER_BIT:UPD_BIT] != 3'b000));

  assert_low_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[3:0] == 4'h0);

  assert_off_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_upd_i && !en_alm_i && !en_per_i) |=> !timer_on_o);

  assert_irq_needs_timer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> timer_on_o);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> (irq_o || flags_o == '0));
endmodule

bind rtcemu_core rtcemu_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .en_upd_i  (en_upd_i),
  .en_alm_i  (en_alm_i),
  .en_per_i  (en_per_i),
  .ack_i     (ack_i),
  .irq_o     (irq_o),
  .flags_o   (flags_o),
  .timer_on_o(timer_on_o)
);

// File: tb/test_rtcemu_core.sv
`timescale 1ns/1ps
module test_rtcemu_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] now;
  logic        en_upd, en_alm, en_per, ack;
  logic [3:0]  rate;
  logic [5:0]  hh, mm, ss;
  logic        irq, timer_on;
  logic [15:0] flags;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rtcemu_core i_rtcemu_core (
    .clk(clk), .rst_n(rst_n), .now_i(now),
    .en_upd_i(en_upd), .en_alm_i(en_alm), .en_per_i(en_per), .rate_i(rate),
    .hh_i(hh), .mm_i(mm), .ss_i(ss),
    .alm_hh_i(6'd1), .alm_mm_i(6'd2), .alm_ss_i(6'd3),
    .ack_i(ack), .irq_o(irq), .flags_o(flags), .timer_on_o(timer_on)
  );

  // {now, hh, mm, ss, expect irq, expect flags}; enables all on, rate 5, interval 128
  localparam logic [50:0] VEC [7] = '{
    {16'd128,  6'd0, 6'd0, 6'd0, 1'b0, 16'h0000},
    {16'd256,  6'd0, 6'd0, 6'd1, 1'b1, 16'h01D0},
    {16'd384,  6'd0, 6'd0, 6'd1, 1'b0, 16'h0000},
    {16'd512,  6'd1, 6'd2, 6'd3, 1'b1, 16'h01F0},
    {16'd906,  6'd1, 6'd2, 6'd3, 1'b1, 16'h01E0},
    {16'd1023, 6'd1, 6'd2, 6'd4, 1'b0, 16'h0000},
    {16'd1024, 6'd1, 6'd2, 6'd4, 1'b1, 16'h0190}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_irq(input int lim, output bit seen, output logic [15:0] fl);
    seen = 1'b0;
    fl   = '0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (irq && !seen) begin
        seen = 1'b1;
        fl   = flags;
      end
    end
  endtask

  task automatic do_ack();
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    finish_up();
  end

  initial begin
    bit          seen;
    logic [15:0] fl;
    rst_n = 1'b0; now = '0; en_upd = 0; en_alm = 0; en_per = 0; ack = 0;
    rate = 4'd5; hh = '0; mm = '0; ss = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(flags == 16'h0, "R1 flags", flags, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(timer_on == 1'b0, "R1 timer", timer_on, 0);

    // arm with all sources, deadline 128
    en_upd = 1; en_alm = 1; en_per = 1;
    repeat (3) @(negedge clk);
    check(timer_on == 1'b1, "R2 timer on", timer_on, 1);

    // R3 R6 R7 R8 R9 table walk
    for (int v = 0; v < 7; v++) begin
      now = VEC[v][50:35];
      hh  = VEC[v][34:29];
      mm  = VEC[v][28:23];
      ss  = VEC[v][22:17];
      wait_irq(14, seen, fl);
      check(seen == VEC[v][16], $sformatf("R3/R6/R7/R8 vec%0d irq", v), seen, VEC[v][16]);
      if (VEC[v][16])
        check(fl == VEC[v][15:0], $sformatf("R9 vec%0d flags", v), fl, VEC[v][15:0]);
      if (seen) do_ack();
    end

    // R10: all disabled, channel stops and stays quiet
    en_upd = 0; en_alm = 0; en_per = 0;
    repeat (2) @(negedge clk);
    check(timer_on == 1'b0, "R10 timer off", timer_on, 0);
    now = 16'd1200;
    wait_irq(12, seen, fl);
    check(!seen, "R10 no irq", seen, 0);

    // R2 R4: fast rate 256 Hz, interval 32
    rate = 4'd8; en_per = 1; now = 16'd5000;
    repeat (3) @(negedge clk);
    check(timer_on == 1'b1, "R2 rearm", timer_on, 1);
    now = 16'd5031;
    wait_irq(10, seen, fl);
    check(!seen, "R2 R4 early", seen, 0);
    now = 16'd5032;
    wait_irq(10, seen, fl);
    check(seen, "R4 fires", seen, 1);
    check(fl == 16'h01C0, "R4 flags", fl, 16'h01C0);

    // R11: no ack, second event ORs in
    en_per = 0; en_upd = 1; ss = 6'd9; now = 16'd5064;
    wait_irq(10, seen, fl);
    check(seen, "R11 second irq", seen, 1);
    check(fl == 16'h01D0, "R11 OR", fl, 16'h01D0);
    do_ack();
    check(flags == 16'h0, "R11 ack", flags, 0);

    // R5: code 15 acts as 13, interval 1
    en_upd = 0;
    repeat (3) @(negedge clk);
    rate = 4'd15; en_per = 1; now = 16'd6000;
    wait_irq(10, seen, fl);
    check(!seen, "R5 clamp early", seen, 0);
    now = 16'd6001;
    wait_irq(10, seen, fl);
    check(seen, "R5 clamp fires", seen, 1);
    check(fl == 16'h01C0, "R5 flags", fl, 16'h01C0);
    do_ack();

    finish_up();
  end
endmodule